// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block decides, once per instruction, whether the processor core should break into an interrupt and, if so, which one. It watches one non-maskable request line, a small set of maskable restart lines that each carry a fixed service address, and one general maskable request that is served through an external acknowledge. The core pulses a sample strobe in the next-to-last clock of every instruction. At that edge the block picks the highest-priority eligible request and reports it for exactly one cycle.

A restart winner comes with its 16-bit service address. A general-request winner instead raises an acknowledge. The core uses that acknowledge to hold its program counter and to take a restart or call opcode from the external device. Every acceptance clears the global enable flag, so nested servicing has to be re-enabled by software. A separate combinational decoder turns a software restart number into its target address.

With the default of three restart lines, line 2 is edge-triggered and latched, while lines 1 and 0 and the general request are level-sensitive. Each restart line has its own mask bit.

Top module: `intc_restart_top`

## Requirements
- R1: After reset the enable flag is 0, all mask bits are 1 (masked), and `take_o` and `ack_o` are 0.
- R2: `en_set_i` sets the enable flag and `en_clr_i` clears it; when both are high in the same cycle the flag is cleared.
- R3: `take_o` can only be high in the cycle right after a clock edge at which `sample_i` was high, and then only for one cycle. When `take_o` is 0, `vec_o` is 0000h and `ack_o` is 0.
- R4: Priority from highest to lowest is `trap_i`, then restart line 2, line 1, line 0, then `gen_i`; only the highest eligible request is accepted.
- R5: `trap_i` is accepted at any sample regardless of the enable flag and the masks, with `vec_o` = 0024h.
- R6: The service addresses are 002Ch for line 0, 0034h for line 1 and 003Ch for line 2; in general, restart line i maps to 0024h + 8·(i+1).
- R7: A mask write (`mask_wr_i`) loads `mask_i` into the masks, with bit i masking restart line i (1 = masked). A masked line is never accepted, and no restart line is accepted while the enable flag is 0.
- R8: Every acceptance clears the enable flag at the same edge, and this overrides an `en_set_i` issued in that cycle.
- R9: A rising edge on restart line 2 is latched and stays pending, whether masked or disabled, until it is accepted, which clears it. Lines 0 and 1 count only while they are high at the sample.
- R10: An accepted general request drives `ack_o` high together with `take_o` and leaves `vec_o` at 0000h.
- R11: `soft_vec_o` equals `soft_num_i` × 8 for every value 0 to 7 (0000h to 0038h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Non-maskable request, level |
| rst_line_i | input | NRST (3) | Restart lines; the top bit is edge-triggered |
| gen_i | input | 1 | General maskable request, level |
| en_set_i | input | 1 | Enable command |
| en_clr_i | input | 1 | Disable command |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_i | input | NRST (3) | Mask data, 1 = masked |
| sample_i | input | 1 | Instruction-boundary sample strobe |
| soft_num_i | input | 3 | Software restart number |
| take_o | output | 1 | Interrupt accepted, one cycle |
| vec_o | output | 16 | Service address of an accepted restart or trap |
| ack_o | output | 1 | Acknowledge for the general request; holds the program counter |
| en_o | output | 1 | Current enable flag |
| mask_o | output | NRST (3) | Current mask bits |
| soft_vec_o | output | 16 | Software restart target address |

## Verification
Directed patterns come first:
- Every request raised at once, with lines then masked one at a time. This walks the whole priority chain and shows that a mask removes exactly its own line.
- A trap with the enable flag cleared and all masks set. This separates the non-maskable path from the gated paths.
- A single-cycle pulse on the edge line, followed by samples with that line low. This tells a latched edge apart from a level request.
- Simultaneous set, clear and acceptance commands. These show which of them wins on the enable flag.

After that, long random runs mix strobes, commands and requests against a cycle model in the bench. They expose ordering and state-update errors that the hand-picked cases do not reach.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int VEC_W    = 16;
  localparam int VEC_STEP = 8;
  localparam logic [VEC_W-1:0] VEC_BASE = 16'h0024;

  // slot 0 = non-maskable, slot k>0 = restart line k-1
  function automatic logic [VEC_W-1:0] hw_vec(input int slot);
    return VEC_BASE + VEC_W'(VEC_STEP * slot);
  endfunction

  // software restart n lands at n*8
  function automatic logic [VEC_W-1:0] soft_addr(input logic [2:0] n);
    return VEC_W'({n, 3'b000});
  endfunction

endpackage

// File: rtl/intc_edge_latch.sv
module intc_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic clear_i,
  output logic pend_o
);
  logic prev_q;
  logic rise;

  assign rise = line_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      prev_q <= line_i;
      if (rise)         pend_o <= 1'b1;
      else if (clear_i) pend_o <= 1'b0;
    end
  end

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o && !clear_i |=> pend_o); // R9
endmodule

// File: rtl/intc_gate_state.sv
module intc_gate_state #(
  parameter int NRST = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_set_i,
  input  logic            en_clr_i,
  input  logic            taken_i,
  input  logic            mask_wr_i,
  input  logic [NRST-1:0] mask_i,
  output logic            en_o,
  output logic [NRST-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o   <= 1'b0;
      mask_o <= '1;
    end else begin
      if (taken_i || en_clr_i) en_o <= 1'b0;
      else if (en_set_i)       en_o <= 1'b1;
      if (mask_wr_i) mask_o <= mask_i;
    end
  end

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_i && !en_clr_i && !taken_i |=> en_o); // R2
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    taken_i |=> !en_o); // R8
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NRST = 3
) (
  input  logic              trap_i,
  input  logic [NRST-1:0]   rst_req_i,
  input  logic              gen_i,
  input  logic              en_i,
  input  logic [NRST-1:0]   mask_i,
  output logic              win_o,
  output logic              win_trap_o,
  output logic              win_gen_o,
  output logic [NRST-1:0]   win_rst_o,
  output logic [VEC_W-1:0]  win_vec_o
);
  localparam int IDXW = (NRST > 1) ? $clog2(NRST) : 1;

  logic [NRST-1:0] elig;
  logic [IDXW-1:0] top_idx;

  genvar g;
  generate
    for (g = 0; g < NRST; g++) begin : g_elig
      assign elig[g] = en_i & ~mask_i[g] & rst_req_i[g];
    end
  endgenerate

  // highest eligible index wins among the restart lines
  always_comb begin
    top_idx = '0;
    for (int i = 0; i < NRST; i++) begin
      if (elig[i]) top_idx = IDXW'(i);
    end
  end

  always_comb begin
    win_trap_o = 1'b0;
    win_gen_o  = 1'b0;
    win_rst_o  = '0;
    win_vec_o  = '0;
    if (trap_i) begin
      win_trap_o = 1'b1;
      win_vec_o  = hw_vec(0);
    end else if (|elig) begin
      win_rst_o[top_idx] = 1'b1;
      win_vec_o          = hw_vec(int'(top_idx) + 1);
    end else if (en_i && gen_i) begin
      win_gen_o = 1'b1;
    end
  end

  assign win_o = win_trap_o | win_gen_o | (|win_rst_o);
endmodule

// File: rtl/intc_restart_top.sv
module intc_restart_top
  import intc_pkg::*;
#(
  parameter int NRST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_i,
  input  logic [NRST-1:0]   rst_line_i,
  input  logic              gen_i,
  input  logic              en_set_i,
  input  logic              en_clr_i,
  input  logic              mask_wr_i,
  input  logic [NRST-1:0]   mask_i,
  input  logic              sample_i,
  input  logic [2:0]        soft_num_i,
  output logic              take_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              ack_o,
  output logic              en_o,
  output logic [NRST-1:0]   mask_o,
  output logic [VEC_W-1:0]  soft_vec_o
);
  logic              edge_pend;
  logic [NRST-1:0]   rst_req;
  logic              win, win_trap, win_gen;
  logic [NRST-1:0]   win_rst;
  logic [VEC_W-1:0]  win_vec;
  logic              taken;

  assign taken = sample_i & win;

  intc_edge_latch u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (rst_line_i[NRST-1]),
    .clear_i (sample_i & win_rst[NRST-1]),
    .pend_o  (edge_pend)
  );

  generate
    if (NRST > 1) begin : g_lvl
      assign rst_req = {edge_pend, rst_line_i[NRST-2:0]};
    end else begin : g_one
      assign rst_req = edge_pend;
    end
  endgenerate

  intc_gate_state #(.NRST(NRST)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_set_i  (en_set_i),
    .en_clr_i  (en_clr_i),
    .taken_i   (taken),
    .mask_wr_i (mask_wr_i),
    .mask_i    (mask_i),
    .en_o      (en_o),
    .mask_o    (mask_o)
  );

  intc_arbiter #(.NRST(NRST)) u_arb (
    .trap_i     (trap_i),
    .rst_req_i  (rst_req),
    .gen_i      (gen_i),
    .en_i       (en_o),
    .mask_i     (mask_o),
    .win_o      (win),
    .win_trap_o (win_trap),
    .win_gen_o  (win_gen),
    .win_rst_o  (win_rst),
    .win_vec_o  (win_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_o <= 1'b0;
      vec_o  <= '0;
      ack_o  <= 1'b0;
    end else begin
      take_o <= taken;
      vec_o  <= taken ? win_vec : '0;
      ack_o  <= sample_i & win_gen;
    end
  end

  assign soft_vec_o = soft_addr(soft_num_i);

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({win_trap, win_gen, win_rst})); // R4
  AST_TAKE_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(sample_i)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> vec_o == '0 && !ack_o); // R3
  AST_ACK_IS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> take_o && vec_o == '0); // R10
  AST_TRAP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i && trap_i |=> take_o && vec_o == hw_vec(0)); // R5
  AST_TAKE_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !en_o); // R8

  generate
    for (genvar k = 0; k < NRST; k++) begin : g_mchk
      AST_MASKED_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o && vec_o == hw_vec(k + 1) |-> !$past(mask_o[k]) && $past(en_o)); // R7
    end
  endgenerate
endmodule

// File: tb/intc_restart_top_tb.sv
module intc_restart_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_i = 0, gen_i = 0, en_set_i = 0, en_clr_i = 0;
  logic        mask_wr_i = 0, sample_i = 0;
  logic [2:0]  rst_line_i = 0, mask_i = 0, soft_num_i = 0;
  logic        take_o, ack_o, en_o;
  logic [15:0] vec_o, soft_vec_o;
  logic [2:0]  mask_o;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic        m_en, m_pend, m_prev, m_take, m_ack;
  logic [2:0]  m_mask;
  logic [15:0] m_vec;

  always #10 clk = ~clk;

  intc_restart_top #(.NRST(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .rst_line_i(rst_line_i),
    .gen_i(gen_i), .en_set_i(en_set_i), .en_clr_i(en_clr_i),
    .mask_wr_i(mask_wr_i), .mask_i(mask_i), .sample_i(sample_i),
    .soft_num_i(soft_num_i), .take_o(take_o), .vec_o(vec_o), .ack_o(ack_o),
    .en_o(en_o), .mask_o(mask_o), .soft_vec_o(soft_vec_o)
  );

  function automatic logic [15:0] line_addr(input int line);
    case (line)
      0: return 16'h002C;
      1: return 16'h0034;
      default: return 16'h003C;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_mask = 3'b111; m_pend = 0; m_prev = 0;
    m_take = 0; m_ack = 0; m_vec = 0;
  endtask

  task automatic model_edge();
    logic g_take, g_ack, g_hi;
    logic [15:0] g_vec;
    g_take = 0; g_ack = 0; g_hi = 0; g_vec = 0;
    if (sample_i) begin
      if (trap_i) begin g_take = 1; g_vec = 16'h0024; end
      else if (m_en && !m_mask[2] && m_pend) begin g_take = 1; g_hi = 1; g_vec = line_addr(2); end
      else if (m_en && !m_mask[1] && rst_line_i[1]) begin g_take = 1; g_vec = line_addr(1); end
      else if (m_en && !m_mask[0] && rst_line_i[0]) begin g_take = 1; g_vec = line_addr(0); end
      else if (m_en && gen_i) begin g_take = 1; g_ack = 1; end
    end
    if (rst_line_i[2] && !m_prev) m_pend = 1;
    else if (g_hi) m_pend = 0;
    m_prev = rst_line_i[2];
    if (g_take || en_clr_i) m_en = 0;
    else if (en_set_i) m_en = 1;
    if (mask_wr_i) m_mask = mask_i;
    m_take = g_take; m_ack = g_ack; m_vec = g_vec;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({tag, " take"}, take_o, m_take);
    chk({tag, " vec"},  vec_o,  m_vec);
    chk({tag, " ack"},  ack_o,  m_ack);
    chk({tag, " en"},   en_o,   m_en);
    chk({tag, " mask"}, mask_o, m_mask);
  endtask

  task automatic quiet();
    trap_i = 0; gen_i = 0; rst_line_i = 0; en_set_i = 0; en_clr_i = 0;
    mask_wr_i = 0; sample_i = 0;
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1BADF00D));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 en", en_o, 0);
    chk("R1 mask", mask_o, 3'b111);
    chk("R1 take", take_o, 0);
    chk("R1 ack", ack_o, 0);
    rst_n = 1;

    // R2: clear beats set
    en_set_i = 1; en_clr_i = 1; step("R2 both");
    en_clr_i = 0; step("R2 set");
    quiet(); step("R2 idle");

    // R3: requests without strobe, then with
    mask_i = 3'b000; mask_wr_i = 1; step("R7 unmask");
    quiet(); rst_line_i = 3'b011; gen_i = 1; step("R3 no strobe");
    sample_i = 1; step("R3 strobe");
    sample_i = 0; step("R3 one cycle");

    // R5: trap with enable off and all masked
    mask_i = 3'b111; mask_wr_i = 1; en_clr_i = 1; step("R5 prep");
    quiet(); trap_i = 1; rst_line_i = 3'b011; gen_i = 1; sample_i = 1; step("R5 trap");
    quiet(); step("R5 after");

    // R4/R6: all requests, walk priority by masking and by re-enabling
    mask_i = 3'b000; mask_wr_i = 1; en_set_i = 1; rst_line_i = 3'b100; step("R9 rise");
    quiet(); rst_line_i = 3'b011; gen_i = 1; trap_i = 1; sample_i = 1; step("R4 trap top");
    trap_i = 0; sample_i = 0; en_set_i = 1; step("R4 reen");
    en_set_i = 0; sample_i = 1; step("R6 line2");
    sample_i = 0; en_set_i = 1; step("R4 reen");
    en_set_i = 0; sample_i = 1; step("R6 line1");
    sample_i = 0; en_set_i = 1; mask_wr_i = 1; mask_i = 3'b010; step("R7 mask line1");
    quiet(); rst_line_i = 3'b011; gen_i = 1; sample_i = 1; step("R6 line0");
    sample_i = 0; en_set_i = 1; mask_wr_i = 1; mask_i = 3'b011; step("R7 mask two");
    quiet(); rst_line_i = 3'b011; gen_i = 1; sample_i = 1; step("R10 gen");
    sample_i = 0; en_set_i = 1; step("R8 reen");
    // R8: acceptance overrides a set in the same cycle
    quiet(); gen_i = 1; sample_i = 1; en_set_i = 1; step("R8 take vs set");
    quiet(); step("R8 stays off");

    // R9: masked edge stays pending, served after unmask
    rst_line_i = 3'b100; mask_wr_i = 1; mask_i = 3'b100; en_set_i = 1; step("R9 masked rise");
    quiet(); sample_i = 1; step("R9 masked sample");
    quiet(); mask_wr_i = 1; mask_i = 3'b000; step("R9 unmask");
    quiet(); sample_i = 1; step("R9 served");
    quiet(); en_set_i = 1; step("R9 reen");
    quiet(); sample_i = 1; step("R9 cleared");

    // R11: software restart decoder
    quiet();
    for (int n = 0; n < 8; n++) begin
      soft_num_i = 3'(n);
      #1;
      chk("R11 soft", soft_vec_o, 16'(n * 8));
    end

    // random mix
    for (int c = 0; c < 4000; c++) begin
      trap_i     = ($urandom % 10) == 0;
      gen_i      = ($urandom % 3) == 0;
      rst_line_i = 3'($urandom);
      en_set_i   = ($urandom % 2) == 0;
      en_clr_i   = ($urandom % 8) == 0;
      mask_wr_i  = ($urandom % 10) == 0;
      mask_i     = 3'($urandom);
      sample_i   = ($urandom % 3) == 0;
      step("R4 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule